// File: doc/BRIEF.md
# 64-bit Integer ALU with NZVC Condition Flags

This block is the arithmetic and logic stage of a small 64-bit integer datapath. In a single combinational pass it adds, subtracts, ANDs, ORs, exclusive-ORs, or shifts left or right. The second operand is either a register value or a 12-bit constant. Any constant is zero-padded on the left to the full width. Shifts move operand A by a count taken from a separate 6-bit field.

Four condition flags sit in a register beside the datapath: negative, zero, overflow and carry. They change only on a rising clock edge in two cases. The first is an operation marked as flag-setting by its strobe. The second is a compare. A compare subtracts B from A, always updates the flags and drives zero on the result port, so no destination value comes out of it.

Top module: `alu_core`

## Requirements
- R1: Operation code 0 drives A+B on the result and code 1 drives A-B, both modulo 2^64.
- R2: Codes 2, 3 and 4 drive the bitwise AND, OR and exclusive-OR of A and B.
- R3: Code 5 shifts A left and code 6 shifts A right, logically, by the 6-bit shift count (0 to 63). Vacated bits are zero and B plays no part.
- R4: With the immediate select high, B is replaced by the 12-bit immediate zero-extended to 64 bits, for every operation that uses B.
- R5: When flags are written, N (flags bit 3) equals bit 63 of the computed value and Z (bit 2) is 1 exactly when that value is all zeros.
- R6: On add, C (bit 0) is the carry out of bit 63 and V (bit 1) is set when both operands share a sign that differs from the sum. On subtract and compare, C is the carry out of A + ~B + 1 and V is set when the operand signs differ and the result sign differs from A.
- R7: A flag-setting AND, OR, exclusive-OR or shift clears C and V.
- R8: For codes 0 to 6 with the set-flags strobe low, the flags keep their value across the clock edge.
- R9: Code 7 (compare) writes the flags of A-B whatever the strobe says, and drives zero on the result.
- R10: An active-low synchronous reset clears all four flags. Flag writes take effect at the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags update on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_i | input | 64 | Operand A, and the value shifted by shift operations |
| b_i | input | 64 | Operand B when the immediate select is low |
| op_i | input | 3 | Operation code: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 shl, 6 shr, 7 compare |
| imm_sel_i | input | 1 | Selects the zero-extended immediate as operand B |
| imm_i | input | 12 | Immediate constant |
| shamt_i | input | 6 | Shift count |
| setf_i | input | 1 | Flag-setting strobe for codes 0 to 6 |
| result_o | output | 64 | Combinational result; zero on compare |
| flags_o | output | 4 | Registered flags {N, Z, V, C} |

## Verification
The checker assumes that the operation code, strobe and operands hold steady through each rising edge. It relates the flags after an edge to the result port seen before that edge for non-compare flag writes. The bench drives every input on the falling edge and holds it through the following rising edge, so the sampled values are the ones the design registered. Random operands are mixed with zero, all-ones and sign-boundary values, so the carry, overflow and zero cases occur often and not just by chance.

// File: rtl/alu_pkg.sv
// Package: shared operation codes and flag layout for the ALU.
// Assumes the 3-bit operation code described in the brief.
package alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_ORR = 3'd3,
        OP_EOR = 3'd4,
        OP_SHL = 3'd5,
        OP_SHR = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } alu_flags_t;

endpackage

// File: rtl/alu_opnd_sel.sv
// Module: picks operand B from the register input or a zero-extended immediate.
// Assumes IMM_W <= DATA_W.
module alu_opnd_sel #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 12
) (
    input  logic [DATA_W-1:0] b_reg,
    input  logic [IMM_W-1:0]  imm,
    input  logic              imm_sel,
    output logic [DATA_W-1:0] b_eff
);
    localparam int PAD_W = DATA_W - IMM_W;

    // Zero-pad the immediate on the left and select it when requested.
    always_comb begin
        if (imm_sel) b_eff = {{PAD_W{1'b0}}, imm};
        else         b_eff = b_reg;
    end
endmodule

// File: rtl/alu_arith.sv
// Module: adder/subtractor producing a sum, carry out and signed overflow.
// Subtraction is done as a + ~b + 1.
module alu_arith #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              carry,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_x;
    logic [DATA_W:0]   wide;

    // Invert B for subtract; the +1 enters as carry-in.
    always_comb begin
        b_x  = sub ? ~b : b;
        wide = {1'b0, a} + {1'b0, b_x} + {{DATA_W{1'b0}}, sub};
    end

    // Split the wide sum and derive signed overflow from the sign bits.
    always_comb begin
        sum   = wide[MSB:0];
        carry = wide[DATA_W];
        ovf   = (a[MSB] == b_x[MSB]) && (wide[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu_logic_shift.sv
// Module: bitwise AND/OR/XOR of A and B and logical shifts of A.
// Assumes the shift count field is clog2(DATA_W) bits wide.
module alu_logic_shift
    import alu_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int SHAMT_W = 6
) (
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    input  logic [SHAMT_W-1:0] shamt,
    input  alu_op_e            op,
    output logic [DATA_W-1:0]  res
);
    logic [DATA_W-1:0] and_v, orr_v, eor_v;

    // One bit slice per data bit for the three bitwise functions.
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
        assign and_v[gi] = a[gi] & b[gi];
        assign orr_v[gi] = a[gi] | b[gi];
        assign eor_v[gi] = a[gi] ^ b[gi];
    end

    // Select the bitwise or shift outcome for the current code.
    always_comb begin
        unique case (op)
            OP_AND:  res = and_v;
            OP_ORR:  res = orr_v;
            OP_EOR:  res = eor_v;
            OP_SHL:  res = a << shamt;
            OP_SHR:  res = a >> shamt;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_flag_reg.sv
// Module: NZVC flag register with synchronous active-low reset.
// Writes the next value only when wr_en is high.
module alu_flag_reg
    import alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  alu_flags_t nxt,
    output alu_flags_t cur
);
    // Hold, clear or load the flags on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)     cur <= '0;
        else if (wr_en) cur <= nxt;
    end
endmodule

// File: rtl/alu_core.sv
// Module: top of the 64-bit ALU; combinational result, registered flags.
// Assumes inputs are stable around each rising clock edge.
module alu_core
    import alu_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int IMM_W   = 12,
    parameter int SHAMT_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  a_i,
    input  logic [DATA_W-1:0]  b_i,
    input  logic [2:0]         op_i,
    input  logic               imm_sel_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  logic               setf_i,
    output logic [DATA_W-1:0]  result_o,
    output logic [3:0]         flags_o
);
    localparam int MSB = DATA_W - 1;

    alu_op_e           op;
    logic [DATA_W-1:0] b_eff, arith_v, logic_v, calc_v;
    logic              is_arith, is_cmp, carry, ovf, wr_en;
    alu_flags_t        nxt_flags, cur_flags;

    // Decode the code into its class.
    always_comb begin
        op       = alu_op_e'(op_i);
        is_cmp   = (op == OP_CMP);
        is_arith = (op == OP_ADD) || (op == OP_SUB) || is_cmp;
    end

    alu_opnd_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
        .b_reg   (b_i),
        .imm     (imm_i),
        .imm_sel (imm_sel_i),
        .b_eff   (b_eff)
    );

    alu_arith #(.DATA_W(DATA_W)) u_arith (
        .a     (a_i),
        .b     (b_eff),
        .sub   (op != OP_ADD),
        .sum   (arith_v),
        .carry (carry),
        .ovf   (ovf)
    );

    alu_logic_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_lgc (
        .a     (a_i),
        .b     (b_eff),
        .shamt (shamt_i),
        .op    (op),
        .res   (logic_v)
    );

    // Merge the unit outputs and build the next flags.
    always_comb begin
        calc_v        = is_arith ? arith_v : logic_v;
        nxt_flags.n   = calc_v[MSB];
        nxt_flags.z   = (calc_v == '0);
        nxt_flags.v   = is_arith & ovf;
        nxt_flags.c   = is_arith & carry;
        wr_en         = setf_i | is_cmp;
        result_o      = is_cmp ? '0 : calc_v;
    end

    alu_flag_reg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .nxt   (nxt_flags),
        .cur   (cur_flags)
    );

    // Expose the flag register as {N, Z, V, C}.
    assign flags_o = cur_flags;
endmodule

// File: rtl/alu_core_chk.sv
// Module: assertion checker for alu_core, attached with bind.
// Assumes inputs are held stable through each rising edge.
module alu_core_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_i,
    input logic              setf_i,
    input logic [DATA_W-1:0] result_o,
    input logic [3:0]        flags_o
);
    // R10
    reset_clears_chk: assert property (@(posedge clk) !rst_n |=> flags_o == 4'b0000);

    // R8
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!setf_i && op_i != 3'd7) |=> $stable(flags_o));

    // R5
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setf_i && op_i != 3'd7) |=> flags_o[3] == $past(result_o[DATA_W-1]));

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setf_i && op_i != 3'd7) |=> flags_o[2] == ($past(result_o) == '0));

    // R7
    logic_cv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setf_i && op_i >= 3'd2 && op_i <= 3'd6) |=> flags_o[1:0] == 2'b00);

    // R9
    cmp_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd7) |-> result_o == '0);
endmodule

bind alu_core alu_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .setf_i   (setf_i),
    .result_o (result_o),
    .flags_o  (flags_o)
);

// File: tb/alu_core_tb.sv
`timescale 1ns/1ps
module alu_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] a_i = '0, b_i = '0;
    logic [2:0]  op_i = '0;
    logic        imm_sel_i = 1'b0;
    logic [11:0] imm_i = '0;
    logic [5:0]  shamt_i = '0;
    logic        setf_i = 1'b0;
    logic [63:0] result_o;
    logic [3:0]  flags_o;

    int checks = 0, errors = 0;
    logic [3:0] mdl_flags = 4'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu_core u_dut (.*);

    function automatic logic [63:0] exp_b(logic [63:0] b, logic sel, logic [11:0] im);
        return sel ? {52'd0, im} : b;
    endfunction

    function automatic logic [63:0] exp_calc(logic [2:0] op, logic [63:0] a, logic [63:0] b, logic [5:0] sh);
        case (op)
            3'd0: return a + b;
            3'd1, 3'd7: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            3'd5: return a << sh;
            default: return a >> sh;
        endcase
    endfunction

    function automatic logic [3:0] exp_flags(logic [2:0] op, logic [63:0] a, logic [63:0] b, logic [5:0] sh);
        logic [63:0] r;
        logic [64:0] w;
        logic c, v;
        r = exp_calc(op, a, b, sh);
        c = 1'b0; v = 1'b0;
        if (op == 3'd0) begin
            w = {1'b0, a} + {1'b0, b};
            c = w[64];
            v = (a[63] == b[63]) && (r[63] != a[63]);
        end else if (op == 3'd1 || op == 3'd7) begin
            c = (a >= b);
            v = (a[63] != b[63]) && (r[63] != a[63]);
        end
        return {r[63], r == 64'd0, v, c};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(logic [2:0] op, logic [63:0] a, logic [63:0] b, logic sel,
                          logic [11:0] im, logic [5:0] sh, logic sf, string req);
        logic [63:0] be, er;
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; imm_sel_i = sel; imm_i = im; shamt_i = sh; setf_i = sf;
        be = exp_b(b, sel, im);
        er = (op == 3'd7) ? 64'd0 : exp_calc(op, a, be, sh);
        #1;
        check(req, result_o, er);
        if (sf || op == 3'd7) mdl_flags = exp_flags(op, a, be, sh);
        @(posedge clk);
        #1;
        check({req, " flags"}, {60'd0, flags_o}, {60'd0, mdl_flags});
    endtask

    function automatic logic [63:0] pick_val();
        case ($urandom_range(0, 5))
            0: return 64'd0;
            1: return '1;
            2: return 64'h8000_0000_0000_0000;
            3: return 64'h7FFF_FFFF_FFFF_FFFF;
            default: return {$urandom(), $urandom()};
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);
        #1;
        check("R10 reset", {60'd0, flags_o}, 64'd0);
        @(negedge clk) rst_n = 1'b1;

        run_op(3'd0, '1, 64'd1, 0, 0, 0, 1, "R1 R6 add wrap carry");
        run_op(3'd1, 64'h8000_0000_0000_0000, 64'd1, 0, 0, 0, 1, "R6 sub overflow");
        run_op(3'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0, 1, "R6 add overflow");
        run_op(3'd2, '1, 64'd0, 1, 12'hFFF, 0, 1, "R4 R7 and imm zero-extend");
        run_op(3'd0, 64'd5, 64'd9, 0, 0, 0, 0, "R8 no flag write");
        run_op(3'd5, 64'd1, 64'd0, 0, 0, 6'd63, 1, "R3 R5 shl by 63");
        run_op(3'd6, 64'h8000_0000_0000_0000, 64'd0, 0, 0, 6'd0, 1, "R3 shr by 0");
        run_op(3'd6, 64'h8000_0000_0000_0000, 64'd0, 0, 0, 6'd63, 0, "R3 shr by 63");
        run_op(3'd7, 64'd42, 64'd42, 0, 0, 0, 0, "R9 compare equal");
        run_op(3'd7, 64'd3, 64'd0, 1, 12'd7, 0, 0, "R9 R4 compare imm");
        run_op(3'd4, 64'hF0F0, 64'hF0F0, 0, 0, 0, 1, "R2 R5 xor zero");
        run_op(3'd3, 64'h1, 64'h8000_0000_0000_0000, 0, 0, 0, 1, "R2 orr negative");

        for (int i = 0; i < 3000; i++) begin
            run_op(3'($urandom_range(0, 7)), pick_val(), pick_val(), 1'($urandom_range(0, 1)),
                   12'($urandom()), 6'($urandom()), 1'($urandom_range(0, 1)), "R1 R2 R3 random");
        end

        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1;
        check("R10 reset again", {60'd0, flags_o}, 64'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule